// File: doc/BRIEF.md
# Reverse-Order Sample Readout Transmitter

This block drains a finished capture from sample memory and hands it, one byte at a time, to a serial transmitter through a valid/ready handshake. It walks the stored samples from the most recent back to the oldest. For each sample it sends only the bytes of the channel groups that are switched on, so narrow captures take less time on the link.

With run-length mode on, consecutive identical samples are folded into a count word followed by the sample value. The top bit of the highest transmitted byte marks a count word. In this mode that bit is always cleared in sample values, so the top enabled channel carries no data. A pulse on `start` launches the readout once capture is complete. The block raises `done` for one cycle after the last byte has been accepted.

Top module: `rle_sample_tx`

## Requirements
- R1: After reset `txValid`, `memRdEn`, `busy` and `done` are all low.
- R2: A readout of `readCount` = k reads exactly 4k samples. The addresses go from 4k-1 down to 0, one step per read, so the newest sample is sent first.
- R3: Channel group g occupies sample bits [8g+7:8g]. Setting bit g of `groupOff` leaves that group out. The remaining groups are sent lowest group first, so each word is n bytes long when n groups are enabled.
- R4: With `rleEn` low, every sample is sent unchanged as its n group bytes, and no count words appear.
- R5: With `rleEn` high, a run of L>1 equal consecutive samples is sent as a count word and then the value. The count word carries L-1 in its low 8n-1 bits and has bit 8n-1 set. A run of length 1 is sent as the value alone.
- R6: With `rleEn` high, bit 8n-1 of every value word is sent as 0. Samples that differ only in that bit belong to the same run.
- R7: With `rleEn` high, a run longer than 2^(8n-1) samples is split into consecutive count/value pairs. Each pair covers at most 2^(8n-1) samples.
- R8: While `txValid` is high and `txReady` is low, `txValid` and `txData` hold their values. No byte is dropped or repeated.
- R9: `done` pulses for exactly one cycle after the last byte is accepted, and `busy` is low in the following cycle. When `readCount` is 0 or all groups are off, `done` follows `start` without any byte or memory read.
- R10: `memRdEn` and `txValid` are low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a readout (taken when idle) |
| readCount | input | COUNT_W | Samples to send, in units of four |
| groupOff | input | 4 | Per-group disable, bit g = 1 drops group g |
| rleEn | input | 1 | Enable run-length folding |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | COUNT_W+2 | Memory read address |
| memData | input | 32 | Read data, valid the cycle after `memRdEn` |
| txData | output | 8 | Byte to transmitter |
| txValid | output | 1 | Byte available |
| txReady | input | 1 | Transmitter accepts the byte |
| busy | output | 1 | Readout in progress |
| done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The checks assume that `readCount`, `groupOff` and `rleEn` hold steady from `start` until `done`. They also assume the memory returns the addressed word exactly one cycle after the read strobe. The bench meets both conditions: it changes the configuration only between readouts, and it models a registered single-port memory. Throttling comes only from `txReady`. The bench drives it either constantly high or from a pseudo-random sequence that pauses the stream at arbitrary bytes, and it never alters any other input mid-readout.

// File: rtl/rle_tx_pkg.sv
package rle_tx_pkg;
  localparam int GRP_N = 4;
  localparam int GRP_W = 8;
  localparam int SMP_W = GRP_N * GRP_W;
  localparam int NB_W  = $clog2(GRP_N + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CMP, ST_FLUSH, ST_SEND_CNT, ST_SEND_VAL, ST_DONE
  } txState_t;

  typedef struct packed {
    logic init;       // latch configuration, arm counters
    logic fetch;      // issue one memory read
    logic adoptNew;   // first sample of a readout opens a run
    logic extend;     // fetched sample continues the run
    logic stash;      // fetched sample ends the run, park it
    logic adoptPend;  // parked sample opens the next run
    logic loadCnt;    // serializer takes the count word
    logic loadVal;    // serializer takes the value word
  } txStrobe_t;

  // gather enabled group bytes into the low end, lowest group first
  function automatic logic [SMP_W-1:0] packGroups(input logic [SMP_W-1:0] smp,
                                                  input logic [GRP_N-1:0] off);
    logic [SMP_W-1:0] res;
    int k;
    res = '0;
    k = 0;
    for (int g = 0; g < GRP_N; g++) begin
      if (!off[g]) begin
        res[k*GRP_W +: GRP_W] = smp[g*GRP_W +: GRP_W];
        k++;
      end
    end
    return res;
  endfunction

  function automatic logic [NB_W-1:0] countOn(input logic [GRP_N-1:0] off);
    logic [NB_W-1:0] res;
    res = '0;
    for (int g = 0; g < GRP_N; g++) begin
      if (!off[g]) res = res + NB_W'(1);
    end
    return res;
  endfunction

  function automatic logic [SMP_W-1:0] tagOf(input logic [NB_W-1:0] nb);
    if (nb == '0) return '0;
    return SMP_W'(1) << (int'(nb) * GRP_W - 1);
  endfunction
endpackage

// File: rtl/rle_tx_dp.sv
module rle_tx_dp
  import rle_tx_pkg::*;
#(
  parameter  int COUNT_W = 8,
  localparam int ADDR_W  = COUNT_W + 2,
  localparam int RUN_W   = COUNT_W + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  txStrobe_t          stb,
  input  logic [COUNT_W-1:0] readCount,
  input  logic [GRP_N-1:0]   groupOff,
  input  logic               rleEn,
  input  logic [SMP_W-1:0]   memData,
  input  logic               txReady,
  output logic               memRdEn,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [GRP_W-1:0]   txData,
  output logic               txValid,
  output logic               noWork,
  output logic               lastFetched,
  output logic               runEmpty,
  output logic               runGt1,
  output logic               runExtend,
  output logic               pending,
  output logic               serLast
);
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W:0]   remainQ;
  logic [GRP_N-1:0]  offQ;
  logic              rleQ;
  logic [NB_W-1:0]   nbQ;
  logic [SMP_W-1:0]  tagQ;
  logic [SMP_W-1:0]  curQ, pendQ, shiftQ;
  logic              pendingQ;
  logic [RUN_W-1:0]  runQ;
  logic [NB_W-1:0]   leftQ;

  logic [SMP_W-1:0]  newVal, countWord;
  logic [32:0]       runLimit;
  logic              atMax, accept;

  // fetched sample, compacted and with the tag position cleared in run mode
  always_comb begin
    newVal = packGroups(memData, offQ);
    if (rleQ) newVal = newVal & ~tagQ;
  end

  always_comb begin
    runLimit = (nbQ == '0) ? 33'd0 : (33'd1 << (int'(nbQ) * GRP_W - 1));
    atMax    = 33'(runQ) >= runLimit;
  end

  assign countWord   = SMP_W'(runQ - RUN_W'(1)) | tagQ;
  assign noWork      = (readCount == '0) || (&groupOff);
  assign lastFetched = (remainQ == '0);
  assign runEmpty    = (runQ == '0);
  assign runGt1      = (runQ > RUN_W'(1));
  assign runExtend   = rleQ && (newVal == curQ) && !atMax;
  assign pending     = pendingQ;
  assign memRdEn     = stb.fetch;
  assign memAddr     = addrQ;

  // sample walk and run bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      remainQ  <= '0;
      offQ     <= '0;
      rleQ     <= 1'b0;
      nbQ      <= '0;
      tagQ     <= '0;
      curQ     <= '0;
      pendQ    <= '0;
      pendingQ <= 1'b0;
      runQ     <= '0;
    end else begin
      if (stb.init) begin
        addrQ    <= {readCount - COUNT_W'(1), 2'b11};
        remainQ  <= {1'b0, readCount, 2'b00};
        offQ     <= groupOff;
        rleQ     <= rleEn;
        nbQ      <= countOn(groupOff);
        tagQ     <= tagOf(countOn(groupOff));
        runQ     <= '0;
        pendingQ <= 1'b0;
      end
      if (stb.fetch) begin
        addrQ   <= addrQ - ADDR_W'(1);
        remainQ <= remainQ - (ADDR_W + 1)'(1);
      end
      if (stb.adoptNew) begin
        curQ <= newVal;
        runQ <= RUN_W'(1);
      end
      if (stb.extend) runQ <= runQ + RUN_W'(1);
      if (stb.stash) begin
        pendQ    <= newVal;
        pendingQ <= 1'b1;
      end
      if (stb.adoptPend) begin
        curQ     <= pendQ;
        runQ     <= RUN_W'(1);
        pendingQ <= 1'b0;
      end
    end
  end

  // byte serializer: low byte first, load wins over shift
  assign txValid = (leftQ != '0);
  assign txData  = shiftQ[GRP_W-1:0];
  assign accept  = txValid && txReady;
  assign serLast = accept && (leftQ == NB_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      leftQ  <= '0;
    end else if (stb.loadCnt || stb.loadVal) begin
      shiftQ <= stb.loadCnt ? countWord : curQ;
      leftQ  <= nbQ;
    end else if (accept) begin
      shiftQ <= shiftQ >> GRP_W;
      leftQ  <= leftQ - NB_W'(1);
    end
  end
endmodule

// File: rtl/rle_tx_ctrl.sv
module rle_tx_ctrl
  import rle_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      noWork,
  input  logic      lastFetched,
  input  logic      runEmpty,
  input  logic      runGt1,
  input  logic      runExtend,
  input  logic      pending,
  input  logic      serLast,
  output txStrobe_t stb,
  output logic      busy,
  output logic      done
);
  txState_t stateQ, stateD;

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        stb.init = 1'b1;
        stateD   = noWork ? ST_DONE : ST_FETCH;
      end
      ST_FETCH: begin
        stb.fetch = 1'b1;
        stateD    = ST_CMP;
      end
      ST_CMP: begin
        if (runEmpty) begin
          stb.adoptNew = 1'b1;
          stateD       = lastFetched ? ST_FLUSH : ST_FETCH;
        end else if (runExtend) begin
          stb.extend = 1'b1;
          stateD     = lastFetched ? ST_FLUSH : ST_FETCH;
        end else begin
          stb.stash = 1'b1;
          stateD    = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (runGt1) begin
          stb.loadCnt = 1'b1;
          stateD      = ST_SEND_CNT;
        end else begin
          stb.loadVal = 1'b1;
          stateD      = ST_SEND_VAL;
        end
      end
      ST_SEND_CNT: if (serLast) begin
        stb.loadVal = 1'b1;
        stateD      = ST_SEND_VAL;
      end
      ST_SEND_VAL: if (serLast) begin
        if (pending) begin
          stb.adoptPend = 1'b1;
          stateD        = lastFetched ? ST_FLUSH : ST_FETCH;
        end else begin
          stateD = ST_DONE;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = (stateQ == ST_DONE);
endmodule

// File: rtl/rle_sample_tx.sv
module rle_sample_tx
  import rle_tx_pkg::*;
#(
  parameter  int COUNT_W = 8,
  localparam int ADDR_W  = COUNT_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COUNT_W-1:0] readCount,
  input  logic [GRP_N-1:0]   groupOff,
  input  logic               rleEn,
  output logic               memRdEn,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [SMP_W-1:0]   memData,
  output logic [GRP_W-1:0]   txData,
  output logic               txValid,
  input  logic               txReady,
  output logic               busy,
  output logic               done
);
  txStrobe_t stb;
  logic noWork, lastFetched, runEmpty, runGt1, runExtend, pending, serLast;

  rle_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .noWork(noWork), .lastFetched(lastFetched), .runEmpty(runEmpty),
    .runGt1(runGt1), .runExtend(runExtend), .pending(pending),
    .serLast(serLast), .stb(stb), .busy(busy), .done(done)
  );

  rle_tx_dp #(.COUNT_W(COUNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .readCount(readCount), .groupOff(groupOff), .rleEn(rleEn),
    .memData(memData), .txReady(txReady),
    .memRdEn(memRdEn), .memAddr(memAddr),
    .txData(txData), .txValid(txValid),
    .noWork(noWork), .lastFetched(lastFetched), .runEmpty(runEmpty),
    .runGt1(runGt1), .runExtend(runExtend), .pending(pending),
    .serLast(serLast)
  );
endmodule

// File: rtl/rle_sample_tx_chk.sv
module rle_sample_tx_chk #(
  parameter  int COUNT_W = 8,
  localparam int ADDR_W  = COUNT_W + 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [COUNT_W-1:0] readCount,
  input logic               memRdEn,
  input logic [ADDR_W-1:0]  memAddr,
  input logic [7:0]         txData,
  input logic               txValid,
  input logic               txReady,
  input logic               busy,
  input logic               done
);
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !txValid && !memRdEn); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R9
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> memAddr <= {readCount, 2'b11}); // R2
  AST_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && $past(memRdEn) |-> 1'b0); // R2
endmodule

bind rle_sample_tx rle_sample_tx_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .readCount(readCount), .memRdEn(memRdEn),
  .memAddr(memAddr), .txData(txData), .txValid(txValid), .txReady(txReady),
  .busy(busy), .done(done)
);

// File: tb/tb_rle_sample_tx.sv
module tb_rle_sample_tx;
  localparam int CLK_PERIOD = 10;
  localparam int COUNT_W    = 8;
  localparam int ADDR_W     = COUNT_W + 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [COUNT_W-1:0] readCount = '0;
  logic [3:0]         groupOff = '0;
  logic               rleEn = 1'b0;
  logic               memRdEn;
  logic [ADDR_W-1:0]  memAddr;
  logic [31:0]        memData;
  logic [7:0]         txData;
  logic               txValid;
  logic               txReady;
  logic               busy;
  logic               done;

  logic [31:0] mem [0:(1<<ADDR_W)-1];
  logic [7:0]  expQ[$];
  string       curReq = "R1";
  int          nChecks = 0;
  int          nFails = 0;
  bit          readyRand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int          expAddr = 0;
  int          readSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rle_sample_tx #(.COUNT_W(COUNT_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .readCount(readCount),
    .groupOff(groupOff), .rleEn(rleEn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memData(memData), .txData(txData), .txValid(txValid), .txReady(txReady),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk) if (memRdEn) memData <= mem[memAddr];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("[TB] FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: drive ready, then score accepted bytes and memory reads
  always @(negedge clk) begin
    if (readyRand) begin
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      txReady = lfsr[0] | lfsr[5];
    end else begin
      txReady = 1'b1;
    end
    #1;
    if (rstN && memRdEn) begin
      check("R2", 32'(memAddr), 32'(expAddr), "read address");
      expAddr--;
      readSeen++;
    end
    if (rstN && txValid && txReady) begin
      if (expQ.size() == 0) check(curReq, {24'd0, txData}, 32'hFFFF_FFFF, "unexpected byte");
      else check(curReq, {24'd0, txData}, {24'd0, expQ.pop_front()}, "byte");
    end
  end

  function automatic logic [31:0] squeeze(logic [31:0] s, logic [3:0] off);
    logic [31:0] r = '0;
    int pos = 0;
    for (int g = 0; g < 4; g++) if (!off[g]) begin
      r[pos +: 8] = s[8*g +: 8];
      pos += 8;
    end
    return r;
  endfunction

  task automatic pushWord(logic [31:0] w, int nb);
    for (int b = 0; b < nb; b++) expQ.push_back(w[8*b +: 8]);
  endtask

  task automatic emitRun(logic [31:0] v, longint run, int nb, logic [31:0] tag);
    if (run > 1) pushWord(32'(run - 1) | tag, nb);
    pushWord(v, nb);
  endtask

  task automatic buildExp(int n, logic [3:0] off, bit rle);
    int nb = 0;
    logic [31:0] tag, cur, v;
    longint maxRun, run;
    for (int g = 0; g < 4; g++) if (!off[g]) nb++;
    if (n == 0 || nb == 0) return;
    tag    = rle ? (32'h1 << (8*nb - 1)) : 32'h0;
    maxRun = 64'd1 << (8*nb - 1);
    run    = 0;
    cur    = '0;
    for (int i = n - 1; i >= 0; i--) begin
      v = squeeze(mem[i], off) & ~tag;
      if (run > 0 && rle && v == cur && run < maxRun) run++;
      else begin
        if (run > 0) emitRun(cur, run, nb, tag);
        cur = v;
        run = 1;
      end
    end
    emitRun(cur, run, nb, tag);
  endtask

  task automatic runTest(string req, int rc, logic [3:0] off, bit rle, bit rnd);
    bit seen = 1'b0;
    int nb = 0;
    for (int g = 0; g < 4; g++) if (!off[g]) nb++;
    curReq    = req;
    readyRand = rnd;
    readCount = COUNT_W'(rc);
    groupOff  = off;
    rleEn     = rle;
    expQ.delete();
    buildExp(rc * 4, off, rle);
    expAddr  = rc * 4 - 1;
    readSeen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int t = 0; t < 20000; t++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    check("R9", 32'(seen), 32'd1, "done pulse");
    @(negedge clk);
    check("R9", 32'(busy), 32'd0, "busy after done");
    check(req, 32'(expQ.size()), 32'd0, "bytes left unsent");
    check("R2", 32'(readSeen), (nb == 0) ? 32'd0 : 32'(rc * 4), "read count");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check("R1", 32'(txValid), 32'd0, "txValid");
    check("R1", 32'(memRdEn), 32'd0, "memRdEn");
    check("R1", 32'(busy), 32'd0, "busy");
    check("R1", 32'(done), 32'd0, "done");

    // R4 / R2: verbatim, newest first, full width
    for (int i = 0; i < 4; i++) mem[i] = 32'h1122_3344 + 32'h0101_0101 * 32'(i);
    runTest("R4", 1, 4'b0000, 1'b0, 1'b0);

    // R3: groups 1 and 3 dropped, throttled link (R8)
    for (int i = 0; i < 8; i++) mem[i] = 32'hA0B0_C0D0 ^ (32'h0103_0507 * 32'(i + 1));
    runTest("R3", 2, 4'b1010, 1'b0, 1'b1);

    // R5: runs of several lengths, all groups
    mem[0] = 32'h0000_0AAA; mem[1] = 32'h0000_0AAA; mem[2] = 32'h0000_0AAA;
    mem[3] = 32'h0BBB_0000; mem[4] = 32'h0CCC_0001; mem[5] = 32'h0CCC_0001;
    mem[6] = 32'h0DDD_0002; mem[7] = 32'h0DDD_0002;
    runTest("R5", 2, 4'b0000, 1'b1, 1'b1);

    // R6: top transmitted bit (sample bit 31 with group 2 off) is masked
    mem[0] = 32'h1200_3456; mem[1] = 32'h9200_3456; mem[2] = 32'h1277_3456;
    mem[3] = 32'hF1FF_0001;
    runTest("R6", 1, 4'b0100, 1'b1, 1'b0);

    // R7: 300 equal bytes in a single group split at 128
    for (int i = 0; i < 300; i++) mem[i] = {8'(i), 8'(3*i), 8'(i + 9), 8'h55};
    runTest("R7", 75, 4'b1110, 1'b1, 1'b1);

    // R4 / R8: larger verbatim stream under backpressure
    for (int i = 0; i < 64; i++) mem[i] = 32'h9E37_79B9 * 32'(i + 3);
    runTest("R8", 16, 4'b0000, 1'b0, 1'b1);

    // R9: nothing to send
    runTest("R9", 0, 4'b0000, 1'b1, 1'b0);
    runTest("R9", 3, 4'b1111, 1'b0, 1'b0);

    // R10: idle again, no strobes
    check("R10", 32'(memRdEn), 32'd0, "memRdEn idle");
    check("R10", 32'(txValid), 32'd0, "txValid idle");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule